// File: doc/BRIEF.md
# Leading-One SAR Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter. Software requests a conversion by setting the busy flag. The sequencer then waits for the sampling network to report that sampling has finished. During that wait, the previous result stays readable. It then resolves the code one bit per conversion-clock tick, starting at the most significant weight. An external comparator judges each trial code presented to the DAC.

Progress is not tracked by a counter. A single marker one travels downward through the result register, and each decided bit is written into the place the marker has just left. Once the marker falls off the bottom, the conversion is finished. Software can clear the busy flag at any moment to stop a conversion. The result register then keeps whatever bits were decided so far, and the lowest set bit marks how far the conversion got.

Top module: `mksar_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy` is 0, `result` is 0 and `trial` is 0.
- R2: A `go_set` pulse while idle with `en` high and `go_clr` low raises `busy` on the next clock edge. `go_set` has no effect while `busy` is already high.
- R3: From the start request until `samp_done`, `result` keeps the value left by the previous conversion.
- R4: A `samp_done` pulse while busy clears `result` to 0 on the next edge. The first `conv_tick` after that loads the marker, giving `result` = 8'h80.
- R5: With a marker present, each `conv_tick` moves the marker one bit lower and writes the decided bit into its former position. `result` does not change on cycles without a tick.
- R6: During conversion, `trial` equals the decided upper bits, then a 1 at the bit under test, then zeros below it; this is the current `result`. Whenever `busy` is 0, `trial` is 0.
- R7: `cmp_hi` = 1 on a tick sets the bit under test to 1. `cmp_hi` = 0 clears it. `cmp_hi` means the trial code is at or below the analog input.
- R8: On the ninth tick after `samp_done`, the marker leaves bit 0. `busy` falls on the same edge, and `result` holds the full 8-bit code.
- R9: `go_clr` while busy returns to idle on the next edge. `result` keeps its partial value: after k ticks (1 to 8), the top k-1 bits are decided, bit 8-k holds the marker, and the bits below are 0.
- R10: `en` low blocks `go_set`, and it stops a running conversion in the same way as `go_clr`, keeping the partial result.
- R11: If `go_clr` and `conv_tick` arrive in the same cycle, the abort wins and `result` is not stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| go_set | input | 1 | Software write of 1 to the busy flag (start request) |
| go_clr | input | 1 | Software write of 0 to the busy flag (abort) |
| conv_tick | input | 1 | Conversion-clock tick, one step per pulse |
| samp_done | input | 1 | End-of-sampling pulse |
| cmp_hi | input | 1 | Comparator decision: trial at or below input |
| result | output | 8 | Result register with progress marker |
| trial | output | 8 | Trial code driven to the DAC |
| busy | output | 1 | Busy/done flag |

## Verification
Every internal register is visible at the ports, so most internal faults show up on the next edge. A marker moved by the wrong amount, or a decided bit written in the wrong place, shows at once in `trial` and `result`. A broken end-of-conversion detection shows as `busy` staying high after the ninth tick, or falling early. A fault in the abort path is caught by checking, straight after the abort, that `busy` has fallen and that `result` still holds the partial value.

// File: rtl/mksar_pkg.sv
package mksar_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_CONV   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mksar_rst_sync.sv
module mksar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/mksar_ctrl.sv
module mksar_ctrl
  import mksar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       en,
  input  logic       go_set,
  input  logic       go_clr,
  input  logic       samp_done,
  input  logic       conv_tick,
  input  logic       last_step,
  output seq_state_e state,
  output logic       clr_res,
  output logic       step_res,
  output logic       busy
);
  seq_state_e state_q, state_d;
  logic       abort;

  assign abort = go_clr | ~en;

  always_comb begin
    state_d  = state_q;
    clr_res  = 1'b0;
    step_res = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (en && go_set && !go_clr) state_d = SEQ_SAMPLE;
      end
      SEQ_SAMPLE: begin
        if (abort) begin
          state_d = SEQ_IDLE;
        end else if (samp_done) begin
          clr_res = 1'b1;
          state_d = SEQ_CONV;
        end
      end
      SEQ_CONV: begin
        if (abort) begin
          state_d = SEQ_IDLE;
        end else if (conv_tick) begin
          step_res = 1'b1;
          if (last_step) state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign state = state_q;
  assign busy  = (state_q != SEQ_IDLE);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SEQ_IDLE && en && go_set && !go_clr) |=> (state_q == SEQ_SAMPLE));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q != SEQ_IDLE && go_clr) |=> (state_q == SEQ_IDLE));

  p_en_low_stop_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!en) |=> (state_q == SEQ_IDLE));

  p_finish_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SEQ_CONV && conv_tick && last_step && en && !go_clr) |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/mksar_result.sv
module mksar_result #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         cmp_i,
  input  logic         conv_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] trial_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] res_q, res_d, step_val, marker;
  logic         empty, load;

  // lowest set bit is the marker: everything below it is still zero
  assign marker = res_q & (~res_q + 1'b1);
  assign empty  = (res_q == '0);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign step_val[i] = empty ? 1'b1 : (marker[i] ? cmp_i : res_q[i]);
    end else begin : g_low
      assign step_val[i] = empty ? 1'b0 :
                           marker[i]   ? cmp_i :
                           marker[i+1] ? 1'b1  : res_q[i];
    end
  end

  assign load  = clr_i | step_i;
  assign res_d = clr_i ? '0 : step_val;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)   res_q <= '0;
    else if (load) res_q <= res_d;
  end

  assign res_o   = res_q;
  assign trial_o = conv_i ? res_q : '0;
  assign last_o  = marker[0];

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_i |=> (res_q == '0));

  p_first_marker_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_i && empty) |=> (res_q == TOP_BIT));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (!clr_i && !step_i) |=> $stable(res_q));

  p_marker_right_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_i && !empty && !marker[0]) |=> ((res_q & (~res_q + 1'b1)) == ($past(marker) >> 1)));

  p_decided_bit_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_i && !empty) |=> (((res_q & $past(marker)) != '0) == $past(cmp_i)));
endmodule

// File: rtl/mksar_seq.sv
module mksar_seq
  import mksar_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         go_set,
  input  logic         go_clr,
  input  logic         conv_tick,
  input  logic         samp_done,
  input  logic         cmp_hi,
  output logic [W-1:0] result,
  output logic [W-1:0] trial,
  output logic         busy
);
  logic       rst_sn;
  seq_state_e state;
  logic       clr_res, step_res, last_step;

  mksar_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  mksar_ctrl u_ctrl (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .en        (en),
    .go_set    (go_set),
    .go_clr    (go_clr),
    .samp_done (samp_done),
    .conv_tick (conv_tick),
    .last_step (last_step),
    .state     (state),
    .clr_res   (clr_res),
    .step_res  (step_res),
    .busy      (busy)
  );

  mksar_result #(.W(W)) u_res (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .clr_i   (clr_res),
    .step_i  (step_res),
    .cmp_i   (cmp_hi),
    .conv_i  (state == SEQ_CONV),
    .res_o   (result),
    .trial_o (trial),
    .last_o  (last_step)
  );

  p_trial_idle_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy) |-> (trial == '0));

  p_abort_freeze_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && go_clr) |=> ($stable(result) && !busy));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && en && go_set && !go_clr) |=> busy);
endmodule

// File: tb/mksar_seq_bench.sv
`timescale 1ns/1ps
module mksar_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n, en, go_set, go_clr, conv_tick, samp_done, cmp_hi;
  logic [7:0] result, trial;
  logic       busy;
  int         target, prev;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp_hi = (int'(trial) <= target);

  mksar_seq u_mksar_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .go_set(go_set), .go_clr(go_clr),
    .conv_tick(conv_tick), .samp_done(samp_done), .cmp_hi(cmp_hi),
    .result(result), .trial(trial), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int partial(input int tgt, input int k);
    int hi;
    if (k == 0) return 0;
    if (k >= 9) return tgt;
    hi = (tgt >> (9 - k)) << (9 - k);
    return hi | (1 << (8 - k));
  endfunction

  // mode: 0 run to completion, 1 abort by go_clr, 2 abort by en low,
  //       3 go_clr together with a tick; stop_k < 0 aborts during sampling
  task automatic run_conv(input int tgt, input int gap, input int stop_k, input int mode);
    int exp;
    target = tgt;
    go_set = 1'b1;
    step();
    go_set = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int s = 0; s < 2; s++) begin
      step();
      chk(result == prev[7:0], "R3 previous result held while sampling", result, prev);
      chk(trial == 8'h00, "R6 trial zero while sampling", trial, 0);
    end
    if (stop_k < 0) begin
      go_clr = 1'b1;
      step();
      go_clr = 1'b0;
      chk(busy == 1'b0 && result == prev[7:0], "R9 abort in sampling keeps result", result, prev);
      return;
    end
    samp_done = 1'b1;
    step();
    samp_done = 1'b0;
    chk(result == 8'h00, "R4 cleared at end of sampling", result, 0);
    for (int k = 1; k <= stop_k; k++) begin
      for (int g = 0; g < gap; g++) begin
        exp = partial(tgt, k - 1);
        go_set = (g == 0);
        step();
        go_set = 1'b0;
        chk(result == exp[7:0] && busy, "R5/R2 no change without tick", result, exp);
      end
      conv_tick = 1'b1;
      step();
      conv_tick = 1'b0;
      exp = partial(tgt, k);
      if (k < 9) begin
        if (k == 1) chk(result == 8'h80, "R4 marker loaded at top", result, 8'h80);
        chk(result == exp[7:0], "R5/R7 marker step", result, exp);
        chk(trial == exp[7:0], "R6 trial code", trial, exp);
        chk(busy == 1'b1, "R8 still busy", busy, 1);
      end else begin
        chk(result == tgt[7:0], "R7/R8 final code", result, tgt);
        chk(busy == 1'b0, "R8 busy falls after ninth tick", busy, 0);
      end
    end
    if (stop_k < 9) begin
      exp = partial(tgt, stop_k);
      if (mode == 2) en = 1'b0; else go_clr = 1'b1;
      if (mode == 3) conv_tick = 1'b1;
      step();
      go_clr = 1'b0; conv_tick = 1'b0; en = 1'b1;
      if (mode == 2)      chk(busy == 0 && result == exp[7:0], "R10 en low stops with partial", result, exp);
      else if (mode == 3) chk(busy == 0 && result == exp[7:0], "R11 abort beats tick", result, exp);
      else                chk(busy == 0 && result == exp[7:0], "R9 abort keeps partial", result, exp);
      for (int t = 0; t < 2; t++) begin
        conv_tick = 1'b1;
        step();
        conv_tick = 1'b0;
        chk(result == exp[7:0] && trial == 8'h00, "R6/R9 idle ignores tick", result, exp);
      end
      prev = exp;
    end else begin
      prev = tgt;
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; go_set = 1'b0; go_clr = 1'b0;
    conv_tick = 1'b0; samp_done = 1'b0; target = 0; prev = 0;
    repeat (3) step();
    chk(busy == 0 && result == 0 && trial == 0, "R1 reset state", result, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk(busy == 0 && result == 0 && trial == 0, "R1 after reset release", result, 0);

    en = 1'b0; go_set = 1'b1;
    step();
    go_set = 1'b0; en = 1'b1;
    chk(busy == 1'b0, "R10 start blocked with en low", busy, 0);

    for (int t = 0; t < 256; t++) run_conv(t, t % 3, 9, 0);

    for (int k = 0; k <= 8; k++) begin
      run_conv(8'hA5 ^ (k * 17), k % 2, k, 1);
      run_conv(8'h3C + k * 13, 1, k, 2);
      run_conv(8'hC3 - k * 7, 0, k, 3);
    end
    run_conv(8'h5A, 0, -1, 1);
    run_conv(8'hFF, 1, 9, 0);
    run_conv(8'h00, 0, 9, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule